// File: doc/BRIEF.md
# Product-Table Window MAC

This block forms the dot product of a 3x3 window of weights with the matching activations. Both operands use a 4-bit power-of-two code. The block has no multiplier and no shifter. Each of the nine weight/activation pairs is turned into an address into a precomputed table of magnitude products, and the entry read there is the unsigned product. The block forms the product sign from the two operand signs and negates the entry when that sign is negative. The nine signed products then pass through a registered adder tree and are added into a 32-bit fixed-point accumulator.

The table of products is symmetric in its two magnitude codes, so only the triangle with `lo <= hi` is stored. The table is written once through a simple write port before inference starts. One copy serves every layer. Nine read ports, one per tap, read the table at the same time. The block accepts a full window on every cycle. It marks the first window of an output pixel with a clear flag, which restarts the running sum instead of adding to it.

Top module: `ptab_mac`

## Requirements
- R1: Each operand code is 4 bits wide. Bit 3 is the sign (1 = negative) and bits 2:0 are the magnitude code. Tap t of a window occupies bits 4t+3:4t of `w_codes` and of `a_codes`.
- R2: A cycle with `tbl_we` high stores `tbl_data` at triangle address `tbl_addr`. The entry for magnitude pair (lo, hi) with lo <= hi lives at address hi*(hi+1)/2 + lo, which gives 36 entries from 0 to 35. A later write to the same address replaces the entry.
- R3: The magnitude of a tap product is the entry addressed by (min, max) of the two magnitude codes. Swapping the weight and activation codes therefore gives the same result.
- R4: A tap product is negative when exactly one of the two sign bits is set. A negative product is subtracted from the sum.
- R5: The window sum is the signed total of all nine tap products.
- R6: The result of a window presented with `in_valid` high shows on the outputs after exactly 5 rising clock edges, with `out_valid` high for that one cycle. Windows can be presented on consecutive cycles, and the block produces one result per valid window.
- R7: A valid window with `clr` high makes the running sum equal to its own window sum. A valid window with `clr` low adds its window sum to the previous running sum. `out_sum` shows the running sum after the update.
- R8: After reset, `out_valid` is low and `out_sum` is zero, and the running sum starts from zero.
- R9: The running sum wraps modulo 2^32.
- R10: A cycle with `in_valid` low, whatever `clr` and the codes hold, leaves the running sum unchanged and produces no result. `out_sum` holds its value while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 6 | Triangle address of the entry being written |
| tbl_data | input | 32 | Product value to store |
| in_valid | input | 1 | A window is present on the code inputs |
| clr | input | 1 | Start a new running sum with this window |
| w_codes | input | 36 | Nine 4-bit weight codes |
| a_codes | input | 36 | Nine 4-bit activation codes |
| out_valid | output | 1 | `out_sum` holds a fresh result |
| out_sum | output | 32 | Running fixed-point sum |

## Verification
The assertions check on every cycle that the state after reset is quiet, that `out_valid` follows `in_valid` exactly five edges later, and that `out_sum` holds steady between results. Only the bench scenarios can show that the values are right. Those scenarios cover triangle addressing and order independence, sign handling, clear-versus-accumulate sequences with idle gaps, table rewrites and wrap-around. The bench checks them against a full 8x8 model of the table.

// File: rtl/ptab_pkg.sv
package ptab_pkg;

    // Number of entries in an adder-tree level after lvl pairwise halvings.
    function automatic int lvl_width(input int base, input int lvl);
        int w;
        w = base;
        for (int k = 0; k < lvl; k++) begin
            w = (w + 1) / 2;
        end
        return w;
    endfunction

    // Entries in the upper triangle of a square table with side n.
    function automatic int tri_depth(input int n);
        return n * (n + 1) / 2;
    endfunction

endpackage

// File: rtl/ptab_store.sv
module ptab_store #(
    parameter int MAG_W  = 3,
    parameter int DATA_W = 32,
    parameter int PORTS  = 9,
    localparam int NMAG  = 1 << MAG_W,
    localparam int DEPTH = ptab_pkg::tri_depth(NMAG),
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [PORTS*AW-1:0]     raddr,
    output logic [PORTS*DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[e] <= '0;
            end else if (we && (waddr == AW'(e))) begin
                mem[e] <= wdata;
            end
        end
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_rd
        logic [AW-1:0] ra;
        assign ra = raddr[p*AW +: AW];
        always_comb begin
            rdata[p*DATA_W +: DATA_W] = '0;
            for (int e = 0; e < DEPTH; e++) begin
                if (ra == AW'(e)) begin
                    rdata[p*DATA_W +: DATA_W] = mem[e];
                end
            end
        end
    end

endmodule

// File: rtl/ptab_lane.sv
module ptab_lane #(
    parameter int MAG_W = 3,
    localparam int NMAG = 1 << MAG_W,
    localparam int AW   = $clog2(ptab_pkg::tri_depth(NMAG)),
    localparam int XW   = 2 * MAG_W + 1
) (
    input  logic [MAG_W:0]  w_code,
    input  logic [MAG_W:0]  a_code,
    output logic [AW-1:0]   addr,
    output logic            neg
);

    logic [MAG_W-1:0] wm;
    logic [MAG_W-1:0] am;
    logic [MAG_W-1:0] hi;
    logic [MAG_W-1:0] lo;

    assign wm  = w_code[MAG_W-1:0];
    assign am  = a_code[MAG_W-1:0];
    assign neg = w_code[MAG_W] ^ a_code[MAG_W];

    always_comb begin
        if (wm > am) begin
            hi = wm;
            lo = am;
        end else begin
            hi = am;
            lo = wm;
        end
        addr = AW'((XW'(hi) * (XW'(hi) + XW'(1))) >> 1) + AW'(lo);
    end

endmodule

// File: rtl/ptab_tree.sv
module ptab_tree #(
    parameter int DATA_W = 32,
    parameter int TAPS   = 9,
    parameter int LEVELS = 3,
    localparam int LAST_W = ptab_pkg::lvl_width(TAPS, LEVELS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_vld,
    input  logic                   in_clr,
    input  logic [TAPS*DATA_W-1:0] in_data,
    output logic                   out_vld,
    output logic                   out_clr,
    output logic [DATA_W-1:0]      out_a,
    output logic [DATA_W-1:0]      out_b
);

    for (genvar l = 0; l <= LEVELS; l++) begin : g_lv
        localparam int LW = ptab_pkg::lvl_width(TAPS, l);
        logic [DATA_W-1:0] s [LW];
        logic              v;
        logic              c;

        if (l == 0) begin : g_in
            for (genvar i = 0; i < LW; i++) begin : g_tap
                assign s[i] = in_data[i*DATA_W +: DATA_W];
            end
            assign v = in_vld;
            assign c = in_clr;
        end else begin : g_reg
            localparam int PW = ptab_pkg::lvl_width(TAPS, l - 1);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v <= 1'b0;
                    c <= 1'b0;
                end else begin
                    v <= g_lv[l-1].v;
                    c <= g_lv[l-1].c;
                end
            end
            for (genvar i = 0; i < LW; i++) begin : g_node
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        s[i] <= '0;
                    end else if (g_lv[l-1].v) begin
                        if (2 * i + 1 < PW) begin
                            s[i] <= g_lv[l-1].s[2*i] + g_lv[l-1].s[2*i+1];
                        end else begin
                            s[i] <= g_lv[l-1].s[2*i];
                        end
                    end
                end
            end
        end
    end

    assign out_vld = g_lv[LEVELS].v;
    assign out_clr = g_lv[LEVELS].c;
    assign out_a   = g_lv[LEVELS].s[0];

    if (LAST_W > 1) begin : g_two
        assign out_b = g_lv[LEVELS].s[1];
    end else begin : g_one
        assign out_b = '0;
    end

endmodule

// File: rtl/ptab_mac.sv
module ptab_mac #(
    parameter int MAG_W     = 3,
    parameter int DATA_W    = 32,
    parameter int TAPS      = 9,
    parameter int TREE_LVLS = 3,
    localparam int CODE_W   = MAG_W + 1,
    localparam int NMAG     = 1 << MAG_W,
    localparam int AW       = $clog2(ptab_pkg::tri_depth(NMAG))
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tbl_we,
    input  logic [AW-1:0]            tbl_addr,
    input  logic [DATA_W-1:0]        tbl_data,
    input  logic                     in_valid,
    input  logic                     clr,
    input  logic [TAPS*CODE_W-1:0]   w_codes,
    input  logic [TAPS*CODE_W-1:0]   a_codes,
    output logic                     out_valid,
    output logic [DATA_W-1:0]        out_sum
);

    logic [TAPS*AW-1:0]     lane_addr;
    logic [TAPS-1:0]        lane_neg;
    logic [TAPS*DATA_W-1:0] lane_mag;
    logic [TAPS*DATA_W-1:0] prod_q;
    logic                   p_vld;
    logic                   p_clr;
    logic                   t_vld;
    logic                   t_clr;
    logic [DATA_W-1:0]      t_a;
    logic [DATA_W-1:0]      t_b;

    for (genvar t = 0; t < TAPS; t++) begin : g_lane
        ptab_lane #(.MAG_W(MAG_W)) u_lane (
            .w_code (w_codes[t*CODE_W +: CODE_W]),
            .a_code (a_codes[t*CODE_W +: CODE_W]),
            .addr   (lane_addr[t*AW +: AW]),
            .neg    (lane_neg[t])
        );
    end

    ptab_store #(.MAG_W(MAG_W), .DATA_W(DATA_W), .PORTS(TAPS)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_data),
        .raddr (lane_addr),
        .rdata (lane_mag)
    );

    // Stage 1: signed tap products.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_vld <= 1'b0;
            p_clr <= 1'b0;
        end else begin
            p_vld <= in_valid;
            p_clr <= in_valid & clr;
        end
    end

    for (genvar t = 0; t < TAPS; t++) begin : g_prod
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prod_q[t*DATA_W +: DATA_W] <= '0;
            end else if (in_valid) begin
                prod_q[t*DATA_W +: DATA_W] <= lane_neg[t] ? -lane_mag[t*DATA_W +: DATA_W]
                                                          :  lane_mag[t*DATA_W +: DATA_W];
            end
        end
    end

    ptab_tree #(.DATA_W(DATA_W), .TAPS(TAPS), .LEVELS(TREE_LVLS)) u_tree (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (p_vld),
        .in_clr  (p_clr),
        .in_data (prod_q),
        .out_vld (t_vld),
        .out_clr (t_clr),
        .out_a   (t_a),
        .out_b   (t_b)
    );

    // Final stage: last tree add merged with the accumulator.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sum   <= '0;
        end else begin
            out_valid <= t_vld;
            if (t_vld) begin
                out_sum <= (t_clr ? '0 : out_sum) + t_a + t_b;
            end
        end
    end

endmodule

// File: rtl/ptab_mac_chk.sv
module ptab_mac_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_sum
);

    logic [2:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc <= '0;
        end else if (cyc != 3'd7) begin
            cyc <= cyc + 3'd1;
        end
    end

    // R8: first sampled cycle after reset shows the cleared outputs
    a_r8_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 3'd0) |-> (!out_valid && out_sum == '0));

    // R6: nothing can emerge before the pipeline has filled
    a_r6_no_early_result: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc < 3'd5) |-> !out_valid);

    // R6: a result appears exactly five edges after a valid window
    a_r6_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 3'd5) |-> (out_valid == $past(in_valid, 5)));

    // R10: the running sum holds while no result is flagged
    a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 3'd1 && !out_valid) |-> $stable(out_sum));

endmodule

bind ptab_mac ptab_mac_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_sum   (out_sum)
);

// File: tb/ptab_mac_test.sv
`timescale 1ns/1ps
module ptab_mac_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [5:0]  tbl_addr = '0;
    logic [31:0] tbl_data = '0;
    logic        in_valid = 1'b0;
    logic        clr = 1'b0;
    logic [35:0] w_codes = '0;
    logic [35:0] a_codes = '0;
    logic        out_valid;
    logic [31:0] out_sum;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    int unsigned cyc = 0;
    logic [31:0] model [8][8];
    logic [31:0] run_acc = '0;
    logic [31:0] exp_q [$];
    int unsigned due_q [$];
    string       tag_q [$];
    bit          done = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    ptab_mac uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tbl_we    (tbl_we),
        .tbl_addr  (tbl_addr),
        .tbl_data  (tbl_data),
        .in_valid  (in_valid),
        .clr       (clr),
        .w_codes   (w_codes),
        .a_codes   (a_codes),
        .out_valid (out_valid),
        .out_sum   (out_sum)
    );

    function automatic logic [31:0] seed_val(input int i, input int j);
        return 32'(((i + j) << 24) | ((i * j) << 8) | (i ^ j));
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R2: write one magnitude pair (lo <= hi) at address hi*(hi+1)/2 + lo
    task automatic write_entry(input int i, input int j, input logic [31:0] val);
        int hi;
        int lo;
        hi = (i > j) ? i : j;
        lo = (i > j) ? j : i;
        model[hi][lo] = val;
        model[lo][hi] = val;
        tbl_we   = 1'b1;
        tbl_addr = 6'(hi * (hi + 1) / 2 + lo);
        tbl_data = val;
        @(negedge clk);
        tbl_we   = 1'b0;
    endtask

    // Driver: presents one window and pushes its expected running sum.
    task automatic drive(input logic [35:0] w, input logic [35:0] a,
                         input logic c, input string tag);
        logic [31:0] wsum;
        wsum = '0;
        for (int t = 0; t < 9; t++) begin
            logic [3:0] wc;
            logic [3:0] ac;
            wc = w[t*4 +: 4];
            ac = a[t*4 +: 4];
            if (wc[3] ^ ac[3]) wsum = wsum - model[wc[2:0]][ac[2:0]];
            else               wsum = wsum + model[wc[2:0]][ac[2:0]];
        end
        run_acc = c ? wsum : run_acc + wsum;
        exp_q.push_back(run_acc);
        due_q.push_back(cyc + 5);
        tag_q.push_back(tag);
        in_valid = 1'b1;
        clr      = c;
        w_codes  = w;
        a_codes  = a;
        @(negedge clk);
        in_valid = 1'b0;
        clr      = 1'b0;
    endtask

    // R10: idle cycles with junk on clr and codes
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            clr     = 1'b1;
            w_codes = 36'hFFFFFFFFF;
            a_codes = 36'h777777777;
            @(negedge clk);
        end
        clr = 1'b0;
    endtask

    // Monitor: pops the scoreboard whenever a result is flagged.
    always @(negedge clk) begin
        if (rst_n && !done && out_valid) begin
            if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R6 unexpected result actual=%h expected=none", out_sum);
            end else begin
                logic [31:0] e;
                int unsigned d;
                string tg;
                e  = exp_q.pop_front();
                d  = due_q.pop_front();
                tg = tag_q.pop_front();
                check(tg, out_sum, e);
                check("R6 latency", 32'(cyc), 32'(d));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset out_valid", 32'(out_valid), 32'd0);
        check("R8 reset out_sum", out_sum, 32'd0);

        for (int i = 0; i < 8; i++)
            for (int j = i; j < 8; j++)
                write_entry(i, j, seed_val(i, j));
        @(negedge clk);

        // R5 R1 R3: positive window, mixed magnitude pairs
        drive(36'h123456707, 36'h765432101, 1'b1, "R5 positive window");
        idle(6);
        // R4: mixed signs
        drive(36'hF9ABCDE8F, 36'h1234C6D8F, 1'b1, "R4 mixed signs");
        idle(6);
        // R3: operands swapped
        drive(36'h1234C6D8F, 36'hF9ABCDE8F, 1'b1, "R3 swapped operands");
        idle(6);
        // R7 R10: accumulate across idle gaps
        drive(36'h111111111, 36'h222222222, 1'b1, "R7 clear start");
        idle(2);
        drive(36'h333333333, 36'hB3B3B3B3B, 1'b0, "R7 accumulate");
        idle(3);
        drive(36'h765000000, 36'h000000567, 1'b0, "R10 after idle junk");
        idle(6);
        // R6: back-to-back windows
        drive(36'h012345670, 36'h076543210, 1'b1, "R6 stream 0");
        drive(36'h89ABCDEF0, 36'h012345678, 1'b0, "R6 stream 1");
        drive(36'h777777777, 36'h111111111, 1'b0, "R6 stream 2");
        drive(36'h000000000, 36'h888888888, 1'b0, "R6 stream 3 zero mags");
        drive(36'h246824682, 36'h135713571, 1'b1, "R6 stream 4 reclear");
        drive(36'h6E5D4C3B2, 36'h2B3C4D5E6, 1'b0, "R6 stream 5");
        idle(8);
        // R2 R9: rewrite the (7,7) entry and wrap the sum
        write_entry(7, 7, 32'hF0000000);
        @(negedge clk);
        drive(36'h777777777, 36'h777777777, 1'b1, "R9 large window");
        drive(36'h777777777, 36'hFFFFFFFFF, 1'b0, "R9 wrap accumulate");
        drive(36'h777777777, 36'h777777777, 1'b0, "R2 rewritten entry");
        idle(10);

        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R6 results missing actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule